// File: doc/BRIEF.md
# Load/Store Multiple Sequencer

This block carries out a block-transfer operation that moves a chosen group of registers between a 16-entry register file and word-addressed memory. The caller supplies the base address and the index of the register that holds it. It also supplies a 16-bit selection vector with one bit per register, the transfer direction, one of two address modes, and a writeback enable. It then pulses `start`. The block walks the selection vector from the lowest set bit upward and turns each selected register into one word access on a simple request/response memory port. It reads the data for stores from the register file and writes returned data into the register file for loads.

Two address modes are supported. In increment-after mode the first access goes to the base and the final base is the base plus four bytes per selected register, which is the form used to pop a stack. In decrement-before mode the block first moves the base down by four bytes per selected register and accesses from there upward, which is the form used to push. Any register may serve as the base, so the block can run stacks that live anywhere in memory, and the updated base lets a copy loop resume where the last transfer ended. When the top register (the program counter) is among the loaded registers, completion carries a branch indication, so a restore and a return happen in one operation.

Top module: `blkxfer_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `mem_req` and `rf_we` are all 0 until a start is accepted.
- R2: Selected registers are transferred in ascending register number. The lowest-numbered one uses the lowest address, and each later access is 4 bytes above the previous one. Every request address has bits [1:0] equal to 0.
- R3: With `dec_before`=0, the first access address equals `base_in`, and `base_out` at completion equals `base_in` + 4·n, where n is the number of set bits in `reg_mask`.
- R4: With `dec_before`=1, the first access address equals `base_in` − 4·n, and `base_out` at completion equals `base_in` − 4·n.
- R5: In the `done` cycle, if `wb_en`=1 and n>0 and the base register was not loaded, the block writes `base_out` into register `base_idx` through the register-file write port. With `wb_en`=0 the base register is left unchanged unless it was loaded.
- R6: An all-zero `reg_mask` raises `done` exactly one clock after the start is accepted. No memory request and no register write occur, and `base_out` equals `base_in` even with `wb_en`=1.
- R7: A store (`is_load`=0) issues exactly one write request per selected register with `mem_wdata` equal to the register addressed by `rf_raddr`. Unselected registers cost no cycles: with memory always ready, `done` rises n+1 clocks after the start.
- R8: A load (`is_load`=1) writes the register file only in a cycle with `mem_rvalid`=1, storing `mem_rdata` into the selected register. While `mem_req`=1 and `mem_ready`=0, the request, its address and its direction are held unchanged into the next cycle.
- R9: `pc_loaded` is 1 in the `done` cycle exactly when the operation was a load whose mask had bit 15 set, and register 15 then holds the loaded word. It is 0 at all other times.
- R10: When a load's mask includes `base_idx`, that register ends with the loaded word and no writeback is performed, even with `wb_en`=1.
- R11: A `start` pulse while `busy`=1 is ignored. The running operation completes with its original parameters.
- R12: `done` is high for exactly one cycle per accepted start, and `base_out` and `pc_loaded` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| dec_before | input | 1 | 1 = decrement-before mode, 0 = increment-after mode |
| wb_en | input | 1 | Write the updated base back to the base register |
| base_idx | input | 4 | Index of the register holding the base |
| base_in | input | 32 | Base byte address (word aligned) |
| reg_mask | input | 16 | One bit per register to transfer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Updated base value, valid with `done` |
| pc_loaded | output | 1 | Program counter was loaded, valid with `done` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |

## Verification
Two functions compete for the single register-file write port. One is the base writeback in the completion cycle. The other is a load returning a word into the register that also serves as the base. The bench provokes this with directed loads and random loads whose mask includes `base_idx` with writeback enabled, under a memory that both stalls acceptance and delays responses at random. The final register contents are judged against a model in which the loaded word wins. Alongside that, the branch indication is checked in the same completion cycle as the base result.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int unsigned BX_DEF_NREG  = 16;
    localparam int unsigned BX_DEF_XLEN  = 32;
    localparam int unsigned BX_DEF_WBYTE = 4;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_WAIT   = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/blkxfer_prienc.sv
// Lowest-set-bit finder over the remaining selection vector.
module blkxfer_prienc #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/blkxfer_popcnt.sv
// Number of selected registers.
module blkxfer_popcnt #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/blkxfer_addrgen.sv
// First access address and final base for both address modes.
module blkxfer_addrgen #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CNTW       = 5,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [XLEN-1:0] base,
    input  logic [CNTW-1:0] cnt,
    input  logic            dec_before,
    output logic [XLEN-1:0] first_addr,
    output logic [XLEN-1:0] final_base
);
    localparam bit IS_POW2 = ((WORD_BYTES & (WORD_BYTES - 1)) == 0);

    logic [XLEN-1:0] span;
    logic [XLEN-1:0] lo_end;
    logic [XLEN-1:0] hi_end;

    generate
        if (IS_POW2) begin : g_shift
            assign span = XLEN'(cnt) << $clog2(WORD_BYTES);
        end else begin : g_mul
            assign span = XLEN'(cnt) * XLEN'(WORD_BYTES);
        end
    endgenerate

    assign lo_end     = base - span;
    assign hi_end     = base + span;
    assign first_addr = dec_before ? lo_end : base;
    assign final_base = dec_before ? lo_end : hi_end;
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int unsigned NREG       = BX_DEF_NREG,
    parameter int unsigned XLEN       = BX_DEF_XLEN,
    parameter int unsigned WORD_BYTES = BX_DEF_WBYTE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    is_load,
    input  logic                    dec_before,
    input  logic                    wb_en,
    input  logic [$clog2(NREG)-1:0] base_idx,
    input  logic [XLEN-1:0]         base_in,
    input  logic [NREG-1:0]         reg_mask,
    output logic                    busy,
    output logic                    done,
    output logic [XLEN-1:0]         base_out,
    output logic                    pc_loaded,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [XLEN-1:0]         mem_addr,
    output logic [XLEN-1:0]         mem_wdata,
    input  logic                    mem_ready,
    input  logic                    mem_rvalid,
    input  logic [XLEN-1:0]         mem_rdata,
    output logic [$clog2(NREG)-1:0] rf_raddr,
    input  logic [XLEN-1:0]         rf_rdata,
    output logic                    rf_we,
    output logic [$clog2(NREG)-1:0] rf_waddr,
    output logic [XLEN-1:0]         rf_wdata
);
    localparam int unsigned IDXW   = $clog2(NREG);
    localparam int unsigned CNTW   = $clog2(NREG + 1);
    localparam int unsigned PC_IDX = NREG - 1;

    typedef struct packed {
        seq_state_e      st;
        logic [NREG-1:0] pend;      // registers still to transfer
        logic [XLEN-1:0] addr;      // address of the next access
        logic            load;
        logic            wb;
        logic [IDXW-1:0] bidx;
        logic [XLEN-1:0] nbase;
        logic            pc_hit;
        logic            base_hit;
        logic            nonempty;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CNTW-1:0] sel_cnt;
    logic [XLEN-1:0] first_addr;
    logic [XLEN-1:0] final_base;
    logic [IDXW-1:0] cur_idx;
    logic [NREG-1:0] pend_after;
    logic            last_one;

    blkxfer_popcnt #(.N(NREG), .CW(CNTW)) u_popcnt (
        .vec (reg_mask),
        .cnt (sel_cnt)
    );

    blkxfer_addrgen #(.XLEN(XLEN), .CNTW(CNTW), .WORD_BYTES(WORD_BYTES)) u_addrgen (
        .base       (base_in),
        .cnt        (sel_cnt),
        .dec_before (dec_before),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    blkxfer_prienc #(.N(NREG), .IW(IDXW)) u_prienc (
        .vec (ctx_q.pend),
        .idx (cur_idx)
    );

    assign pend_after = ctx_q.pend & ~(NREG'(1) << cur_idx);
    assign last_one   = (pend_after == '0);

    always_comb begin
        ctx_d    = ctx_q;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        rf_we    = 1'b0;
        rf_waddr = cur_idx;
        rf_wdata = mem_rdata;
        done     = 1'b0;

        unique case (ctx_q.st)
            SQ_IDLE: begin
                if (start) begin
                    ctx_d.st       = (reg_mask == '0) ? SQ_FINISH : SQ_ISSUE;
                    ctx_d.pend     = reg_mask;
                    ctx_d.addr     = first_addr;
                    ctx_d.load     = is_load;
                    ctx_d.wb       = wb_en;
                    ctx_d.bidx     = base_idx;
                    ctx_d.nbase    = final_base;
                    ctx_d.pc_hit   = is_load & reg_mask[PC_IDX];
                    ctx_d.base_hit = is_load & reg_mask[base_idx];
                    ctx_d.nonempty = |reg_mask;
                end
            end
            SQ_ISSUE: begin
                mem_req = 1'b1;
                mem_we  = ~ctx_q.load;
                if (mem_ready) begin
                    if (ctx_q.load) begin
                        ctx_d.st = SQ_WAIT;
                    end else begin
                        ctx_d.pend = pend_after;
                        ctx_d.addr = ctx_q.addr + XLEN'(WORD_BYTES);
                        ctx_d.st   = last_one ? SQ_FINISH : SQ_ISSUE;
                    end
                end
            end
            SQ_WAIT: begin
                if (mem_rvalid) begin
                    rf_we      = 1'b1;
                    ctx_d.pend = pend_after;
                    ctx_d.addr = ctx_q.addr + XLEN'(WORD_BYTES);
                    ctx_d.st   = last_one ? SQ_FINISH : SQ_ISSUE;
                end
            end
            SQ_FINISH: begin
                done = 1'b1;
                if (ctx_q.wb && ctx_q.nonempty && !ctx_q.base_hit) begin
                    rf_we    = 1'b1;
                    rf_waddr = ctx_q.bidx;
                    rf_wdata = ctx_q.nbase;
                end
                ctx_d.st = SQ_IDLE;
            end
            default: ctx_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy      = (ctx_q.st != SQ_IDLE);
    assign base_out  = ctx_q.nbase;
    assign pc_loaded = done & ctx_q.pc_hit;
    assign mem_addr  = ctx_q.addr;
    assign mem_wdata = rf_rdata;
    assign rf_raddr  = cur_idx;

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            pc_loaded,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready,
    input logic            mem_rvalid,
    input logic            rf_we
);
    logic            seen_q;
    logic [XLEN-1:0] next_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            next_addr_q <= '0;
        end else if (done) begin
            seen_q <= 1'b0;
        end else if (mem_req && mem_ready) begin
            seen_q      <= 1'b1;
            next_addr_q <= mem_addr + XLEN'(4);
        end
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && seen_q) |-> (mem_addr == next_addr_q));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we)
             && (!mem_we || $stable(mem_wdata))));

    // R8
    rf_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !done) |-> mem_rvalid);

    // R9
    pc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_loaded |-> done);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done) |-> busy);

endmodule

bind blkxfer_seq blkxfer_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .pc_loaded  (pc_loaded),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .rf_we      (rf_we)
);

// File: tb/blkxfer_seq_bench.sv
`timescale 1ns/1ps
module blkxfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_load = 1'b0;
    logic        dec_before = 1'b0;
    logic        wb_en = 1'b0;
    logic [3:0]  base_idx = '0;
    logic [31:0] base_in = '0;
    logic [15:0] reg_mask = '0;
    logic        busy, done, pc_loaded;
    logic [31:0] base_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready, mem_rvalid;
    logic [31:0] mem_rdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;

    logic [31:0] rf_m   [16];
    logic [31:0] mem_m  [256];
    logic [31:0] exp_rf [16];
    logic [31:0] exp_mem[256];

    int  n_chk = 0;
    int  n_fail = 0;
    int  acc_total = 0;
    bit  fast = 1'b1;
    logic        pend_q = 1'b0;
    logic [31:0] pend_addr = '0;

    always #2.5 clk = ~clk;

    blkxfer_seq u_blkxfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
        .dec_before(dec_before), .wb_en(wb_en), .base_idx(base_idx),
        .base_in(base_in), .reg_mask(reg_mask), .busy(busy), .done(done),
        .base_out(base_out), .pc_loaded(pc_loaded), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    assign rf_rdata = rf_m[rf_raddr];

    // Register file and memory models
    always @(posedge clk) begin
        if (rf_we) rf_m[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ready) begin
            acc_total <= acc_total + 1;
            if (mem_we) mem_m[mem_addr[9:2]] <= mem_wdata;
        end
        if (mem_req && mem_ready && !mem_we) begin
            pend_q    <= 1'b1;
            pend_addr <= mem_addr;
        end else if (mem_rvalid) begin
            pend_q <= 1'b0;
        end
    end

    // Memory responder, driven between edges
    initial begin
        mem_ready  = 1'b0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (fast) begin
                mem_ready  = 1'b1;
                mem_rvalid = pend_q;
            end else begin
                mem_ready  = ($urandom_range(3) != 0);
                mem_rvalid = pend_q && ($urandom_range(2) != 0);
            end
            mem_rdata = mem_m[pend_addr[9:2]];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic run_op(input bit ld, input bit db, input bit wb, input logic [3:0] bi,
                          input logic [15:0] mk, input bit inject, input string rf_tag,
                          output int cyc);
        logic [31:0] base, a, nb;
        int n, acc0, bad;
        bit pc_e, ok;
        string bt;
        base = rf_m[bi];
        n = popc(mk);
        for (int i = 0; i < 16; i++) exp_rf[i] = rf_m[i];
        for (int i = 0; i < 256; i++) exp_mem[i] = mem_m[i];
        a  = db ? base - 32'(4 * n) : base;
        nb = db ? base - 32'(4 * n) : base + 32'(4 * n);
        for (int r = 0; r < 16; r++) begin
            if (mk[r]) begin
                if (ld) exp_rf[r] = mem_m[a[9:2]];
                else    exp_mem[a[9:2]] = rf_m[r];
                a = a + 32'd4;
            end
        end
        if (wb && n != 0 && !(ld && mk[bi])) exp_rf[bi] = nb;
        pc_e = ld && mk[15];
        acc0 = acc_total;

        is_load = ld; dec_before = db; wb_en = wb; base_idx = bi;
        base_in = base; reg_mask = mk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (inject && !done) begin
            // R11: a second start while busy must be ignored
            start = 1'b1; is_load = ~ld; reg_mask = 16'hffff;
            base_in = 32'h0; wb_en = 1'b1; dec_before = ~db;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        bt = (n == 0) ? "R6" : (db ? "R4" : "R3");
        chk(done == 1'b1, "R12 done", 32'(done), 32'd1);
        chk(base_out == nb, bt, base_out, nb);
        chk(pc_loaded == pc_e, "R9", 32'(pc_loaded), 32'(pc_e));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R12 single pulse", 32'({done, busy}), 32'd0);
        ok = 1'b1; bad = 0;
        for (int i = 0; i < 16; i++) if (ok && rf_m[i] !== exp_rf[i]) begin ok = 1'b0; bad = i; end
        chk(ok, rf_tag, rf_m[bad], exp_rf[bad]);
        ok = 1'b1; bad = 0;
        for (int i = 0; i < 256; i++) if (ok && mem_m[i] !== exp_mem[i]) begin ok = 1'b0; bad = i; end
        chk(ok, "R2 memory image", mem_m[bad], exp_mem[bad]);
        chk((acc_total - acc0) == n, "R7 access count", 32'(acc_total - acc0), 32'(n));
    endtask

    task automatic set_base(input logic [3:0] bi);
        rf_m[bi] = 32'h100 + 32'(4 * $urandom_range(127));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        bit ld, db, wb;
        logic [3:0] bi;
        logic [15:0] mk;
        string tg;
        void'($urandom(32'h1bd5_07c3));
        for (int i = 0; i < 16; i++) rf_m[i] = $urandom;
        for (int i = 0; i < 256; i++) mem_m[i] = $urandom;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, done, mem_req, rf_we} == 4'b0, "R1 in reset", 32'({busy, done, mem_req, rf_we}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, mem_req, rf_we} == 4'b0, "R1 after reset", 32'({busy, done, mem_req, rf_we}), 32'd0);

        // R6: empty mask with writeback
        set_base(4'd13);
        run_op(1'b1, 1'b0, 1'b1, 4'd13, 16'h0000, 1'b0, "R6 regs untouched", cyc);
        chk(cyc == 1, "R6 latency", 32'(cyc), 32'd1);

        // R4/R7: push r4..r11 below r13, memory always ready
        set_base(4'd13);
        run_op(1'b0, 1'b1, 1'b1, 4'd13, 16'h0FF0, 1'b0, "R5 push writeback", cyc);
        chk(cyc == 9, "R7 store latency", 32'(cyc), 32'd9);

        // R3/R9: pop r11 and r15 back
        run_op(1'b1, 1'b0, 1'b1, 4'd13, 16'h8800, 1'b0, "R9 pop into pc", cyc);

        // R10: base register also loaded
        set_base(4'd2);
        run_op(1'b1, 1'b0, 1'b1, 4'd2, 16'h0027, 1'b0, "R10 loaded base wins", cyc);

        // R5: no writeback leaves base alone
        set_base(4'd6);
        run_op(1'b0, 1'b0, 1'b0, 4'd6, 16'h1041, 1'b0, "R5 no writeback", cyc);

        // R7: single and full masks
        set_base(4'd0);
        run_op(1'b0, 1'b0, 1'b1, 4'd0, 16'hFFFF, 1'b0, "R7 full store", cyc);
        chk(cyc == 17, "R7 full store latency", 32'(cyc), 32'd17);
        set_base(4'd9);
        run_op(1'b0, 1'b1, 1'b1, 4'd9, 16'h0008, 1'b0, "R7 single store", cyc);
        chk(cyc == 2, "R7 single store latency", 32'(cyc), 32'd2);

        // R11: start pulse while busy
        set_base(4'd5);
        run_op(1'b1, 1'b0, 1'b1, 4'd5, 16'h0C10, 1'b1, "R11 busy start ignored", cyc);

        // Random operations under a stalling memory
        fast = 1'b0;
        for (int k = 0; k < 250; k++) begin
            ld = $urandom_range(1);
            db = $urandom_range(1);
            wb = ($urandom_range(3) != 0);
            bi = 4'($urandom_range(15));
            case ($urandom_range(7))
                0:       mk = 16'h0000;
                1:       mk = 16'hFFFF;
                default: mk = 16'($urandom);
            endcase
            if (k % 5 == 0) fast = ~fast;
            set_base(bi);
            if (ld && mk[bi])      tg = "R10 random";
            else if (ld && mk[15]) tg = "R9 random";
            else if (ld)           tg = "R8 random load";
            else if (wb)           tg = "R5 random";
            else                   tg = "R7 random store";
            run_op(ld, db, wb, bi, mk, (k % 7 == 3), tg, cyc);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule